// File: doc/BRIEF.md
# Critical-Mode PFC Gate Sequencer

This block drives the switch gate of a boost power-factor stage that runs in critical conduction mode. Comparators outside the block hand it three synchronous flags: the inductor current has reached zero, the switch current has passed its peak limit, and the shutdown pin is being held low. A separate input gives the on-time wanted for the next pulse as a count of clock cycles. It stands in for the result of the amplitude-versus-ramp comparison.

Each switching cycle the gate turns on when the zero-current flag falls and stays on for the requested count. The count is capped at a maximum. A peak-current trip ends the pulse early, but only once a short blanking window after turn-on has passed. After every pulse the gate stays off for at least an inhibit interval. If no zero-current edge is accepted, a restart timer forces the next pulse. A low enable, or a shutdown flag that has been held long enough, stops switching and returns every timer to idle. All durations are given in nanoseconds and converted to cycles from a clock-frequency parameter, always rounding up.

Top module: `pfc_gate_seq`

## Requirements
- R1: While reset is asserted, and after release until a pulse starts, gateOut is 0. With no accepted zero-current edge, the first pulse starts on the RST-th clock edge after the first edge out of reset.
- R2: A pulse lasts exactly onReq clock cycles when 1 <= onReq <= MAXON. onReq is sampled on the edge that raises the gate.
- R3: A pulse never lasts more than MAXON cycles. Any onReq above MAXON gives exactly MAXON.
- R4: A falling zcdFlag (1 on one edge, 0 on the next) raises the gate on the edge that sees the 0, if the gate has by then been low for at least INH cycles. The off interval then equals the number of low cycles up to that edge.
- R5: A falling zcdFlag that would give an off interval shorter than INH cycles is ignored and is not remembered.
- R6: If no edge is accepted, the gate rises after exactly RST low cycles, counted from the end of the previous pulse.
- R7: When ocpFlag is 1 on an edge at which the gate has been high for at least BLANK cycles, the gate is low from that edge on. A trip held from turn-on gives a pulse of BLANK+1 cycles.
- R8: ocpFlag on the edges that close the first BLANK high cycles has no effect on the pulse width.
- R9: When onReq is 0 at a start event, no pulse is produced, and a new off interval (with its own restart count) begins at that edge.
- R10: When enable is 0 on an edge, gateOut is 0 after that edge and all timers are cleared. The gate rises RST edges after the first edge that sees enable at 1 again.
- R11: disFlag held 1 on DIS consecutive edges stops switching: the gate is low after the next edge, and zero-current edges are ignored while stopped.
- R12: disFlag held for fewer than DIS edges has no effect. After the flag clears, the gate rises on the (RST+1)-th edge after the first edge that sees it at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Global switching enable |
| zcdFlag | input | 1 | Zero-current comparator output; falling edge starts a cycle |
| ocpFlag | input | 1 | Peak-current comparator output |
| disFlag | input | 1 | Shutdown-pin-low flag, debounced inside |
| onReq | input | ON_W | Requested on-time in clock cycles |
| gateOut | output | 1 | Registered gate drive |

## Verification
The gate is a register, so every effect shows up one edge after the edge that samples its cause. A zero-current fall or a trip driven in a cycle changes the gate at the next edge. An enable change needs one edge to clear the gate and one more to re-arm the off timer. A released shutdown flag needs two edges before the restart count begins. The bench drives inputs and samples the gate on the falling clock edge, and measures each pulse and each off interval as a count of such samples. It compares those counts with the cycle totals given above: exact pulse widths, off intervals of exactly INH, RST, 2*RST, RST+1 and RST+2 samples, and a trip width of BLANK+1.

// File: rtl/pfc_gate_pkg.sv
package pfc_gate_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_ON, ST_OFF} seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrCnt;
    logic incCnt;
    logic latchOn;
    logic gateSet;
    logic gateClr;
  } ctrlStrobe_t;

  // conditions from datapath to control
  typedef struct packed {
    logic halt;
    logic zcdFall;
    logic ocpHit;
    logic onDone;
    logic offReady;
    logic restartDue;
    logic reqZero;
  } dpStatus_t;

  // nanoseconds to clock cycles, rounded up
  function automatic int nsToCyc(longint hz, longint ns);
    return int'((hz * ns + 64'd999_999_999) / 64'd1_000_000_000);
  endfunction

endpackage

// File: rtl/pfc_gate_dp.sv
module pfc_gate_dp
  import pfc_gate_pkg::*;
#(
  parameter int ON_W      = 16,
  parameter int CNT_W     = 16,
  parameter int DIS_W     = 16,
  parameter int INH_CYC   = 250,
  parameter int RST_CYC   = 50000,
  parameter int MAXON_CYC = 2500,
  parameter int BLANK_CYC = 18,
  parameter int DIS_CYC   = 15000
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            enable,
  input  logic            zcdFlag,
  input  logic            ocpFlag,
  input  logic            disFlag,
  input  logic [ON_W-1:0] onReq,
  input  ctrlStrobe_t     strb,
  output dpStatus_t       st,
  output logic            gateOut
);
  localparam logic [CNT_W-1:0] INH_M1  = CNT_W'(INH_CYC - 1);
  localparam logic [CNT_W-1:0] RST_M1  = CNT_W'(RST_CYC - 1);
  localparam logic [CNT_W-1:0] MAXON_V = CNT_W'(MAXON_CYC);
  localparam logic [CNT_W-1:0] BLANK_V = CNT_W'(BLANK_CYC);
  localparam logic [DIS_W-1:0] DIS_V   = DIS_W'(DIS_CYC);

  logic             zcdPrev;
  logic [DIS_W-1:0] disCnt;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] onLen;
  logic             gateQ;
  logic             stopped;

  assign stopped = (disCnt == DIS_V);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      zcdPrev <= 1'b0;
      disCnt  <= '0;
    end else begin
      zcdPrev <= zcdFlag;
      if (!disFlag)      disCnt <= '0;
      else if (!stopped) disCnt <= disCnt + DIS_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt   <= '0;
      onLen <= '0;
      gateQ <= 1'b0;
    end else begin
      if (strb.clrCnt)      cnt <= '0;
      else if (strb.incCnt) cnt <= cnt + CNT_W'(1);
      if (strb.latchOn) begin
        if (32'(onReq) > MAXON_CYC) onLen <= MAXON_V;
        else                        onLen <= CNT_W'(onReq);
      end
      if (strb.gateClr)      gateQ <= 1'b0;
      else if (strb.gateSet) gateQ <= 1'b1;
    end
  end

  always_comb begin
    st.halt       = !enable || stopped;
    st.zcdFall    = zcdPrev && !zcdFlag;
    st.ocpHit     = ocpFlag && (cnt >= BLANK_V);
    st.onDone     = (cnt == onLen - CNT_W'(1));
    st.offReady   = (cnt >= INH_M1);
    st.restartDue = (cnt >= RST_M1);
    st.reqZero    = (onReq == '0);
  end

  assign gateOut = gateQ;

endmodule

// File: rtl/pfc_gate_ctrl.sv
module pfc_gate_ctrl
  import pfc_gate_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dpStatus_t   st,
  output ctrlStrobe_t strb
);
  seqState_t state, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    nxt  = state;
    strb = '0;
    if (st.halt) begin
      nxt          = ST_IDLE;
      strb.gateClr = 1'b1;
      strb.clrCnt  = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          nxt         = ST_OFF;
          strb.clrCnt = 1'b1;
        end
        ST_ON: begin
          if (st.onDone || st.ocpHit) begin
            nxt          = ST_OFF;
            strb.gateClr = 1'b1;
            strb.clrCnt  = 1'b1;
          end else begin
            strb.incCnt = 1'b1;
          end
        end
        ST_OFF: begin
          if ((st.zcdFall && st.offReady) || st.restartDue) begin
            strb.clrCnt = 1'b1;
            if (!st.reqZero) begin
              nxt          = ST_ON;
              strb.gateSet = 1'b1;
              strb.latchOn = 1'b1;
            end
          end else begin
            strb.incCnt = 1'b1;
          end
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pfc_gate_seq.sv
module pfc_gate_seq
  import pfc_gate_pkg::*;
#(
  parameter longint CLK_HZ     = 100_000_000,
  parameter int     ON_W       = 16,
  parameter int     INHIBIT_NS = 2_500,
  parameter int     RESTART_NS = 500_000,
  parameter int     MAX_ON_NS  = 25_000,
  parameter int     BLANK_NS   = 180,
  parameter int     DISABLE_NS = 150_000
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            enable,
  input  logic            zcdFlag,
  input  logic            ocpFlag,
  input  logic            disFlag,
  input  logic [ON_W-1:0] onReq,
  output logic            gateOut
);
  localparam int INH_CYC   = nsToCyc(CLK_HZ, INHIBIT_NS);
  localparam int RST_CYC   = nsToCyc(CLK_HZ, RESTART_NS);
  localparam int MAXON_CYC = nsToCyc(CLK_HZ, MAX_ON_NS);
  localparam int BLANK_CYC = nsToCyc(CLK_HZ, BLANK_NS);
  localparam int DIS_CYC   = nsToCyc(CLK_HZ, DISABLE_NS);
  localparam int CNT_MAX   = (RST_CYC > MAXON_CYC) ? RST_CYC : MAXON_CYC;
  localparam int CNT_W     = $clog2(CNT_MAX + 1);
  localparam int DIS_W     = $clog2(DIS_CYC + 1);

  ctrlStrobe_t strb;
  dpStatus_t   st;

  pfc_gate_ctrl u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .st   (st),
    .strb (strb)
  );

  pfc_gate_dp #(
    .ON_W(ON_W), .CNT_W(CNT_W), .DIS_W(DIS_W),
    .INH_CYC(INH_CYC), .RST_CYC(RST_CYC), .MAXON_CYC(MAXON_CYC),
    .BLANK_CYC(BLANK_CYC), .DIS_CYC(DIS_CYC)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .enable  (enable),
    .zcdFlag (zcdFlag),
    .ocpFlag (ocpFlag),
    .disFlag (disFlag),
    .onReq   (onReq),
    .strb    (strb),
    .st      (st),
    .gateOut (gateOut)
  );

endmodule

// File: rtl/pfc_gate_seq_chk.sv
module pfc_gate_seq_chk
  import pfc_gate_pkg::*;
#(
  parameter longint CLK_HZ     = 100_000_000,
  parameter int     INHIBIT_NS = 2_500,
  parameter int     MAX_ON_NS  = 25_000,
  parameter int     BLANK_NS   = 180
) (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic ocpFlag,
  input logic gateOut
);
  localparam int INH   = nsToCyc(CLK_HZ, INHIBIT_NS);
  localparam int MAXON = nsToCyc(CLK_HZ, MAX_ON_NS);
  localparam int BLANK = nsToCyc(CLK_HZ, BLANK_NS);

  int lowRun;
  int highRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowRun  <= 0;
      highRun <= 0;
    end else begin
      if (gateOut) begin
        lowRun <= 0;
        if (highRun < 32'h7fff_ffff) highRun <= highRun + 1;
      end else begin
        highRun <= 0;
        if (lowRun < 32'h7fff_ffff) lowRun <= lowRun + 1;
      end
    end
  end

  assert_gate_drop_R10: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !gateOut);

  assert_rise_enabled_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateOut) |-> $past(enable));

  assert_on_cap_R3: assert property (@(posedge clk) disable iff (!rstN)
    highRun <= MAXON);

  assert_min_off_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateOut) |-> lowRun >= INH);

  assert_trip_ends_R7: assert property (@(posedge clk) disable iff (!rstN)
    (gateOut && ocpFlag && highRun >= BLANK) |=> !gateOut);

endmodule

bind pfc_gate_seq pfc_gate_seq_chk #(
  .CLK_HZ(CLK_HZ), .INHIBIT_NS(INHIBIT_NS), .MAX_ON_NS(MAX_ON_NS), .BLANK_NS(BLANK_NS)
) u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .ocpFlag(ocpFlag), .gateOut(gateOut)
);

// File: tb/pfc_gate_seq_bench.sv
module pfc_gate_seq_bench;
  localparam longint CLK_HZ = 10_000_000;
  localparam int INH_NS = 2_500, RST_NS = 500_000, MAXON_NS = 25_000;
  localparam int BLANK_NS = 180, DIS_NS = 10_000;

  function automatic int toCyc(longint ns);
    return int'((CLK_HZ * ns + 999_999_999) / 1_000_000_000);
  endfunction

  localparam int INH = toCyc(INH_NS);
  localparam int RST = toCyc(RST_NS);
  localparam int MAXON = toCyc(MAXON_NS);
  localparam int BLANK = toCyc(BLANK_NS);
  localparam int DIS = toCyc(DIS_NS);

  function automatic int expOn(int req);
    return (req > MAXON) ? MAXON : req;
  endfunction

  logic clk = 0, rstN = 0, enable = 1, zcdFlag = 1, ocpFlag = 0, disFlag = 0;
  logic [15:0] onReq = 16'd10;
  logic gateOut;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pfc_gate_seq #(
    .CLK_HZ(CLK_HZ), .ON_W(16), .INHIBIT_NS(INH_NS), .RESTART_NS(RST_NS),
    .MAX_ON_NS(MAXON_NS), .BLANK_NS(BLANK_NS), .DISABLE_NS(DIS_NS)
  ) u_pfc_gate_seq (
    .clk(clk), .rstN(rstN), .enable(enable), .zcdFlag(zcdFlag),
    .ocpFlag(ocpFlag), .disFlag(disFlag), .onReq(onReq), .gateOut(gateOut)
  );

  task automatic chkEq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // count consecutive low samples, current one included
  task automatic lowRun(output int n);
    n = 0;
    while (!gateOut && n < 20000) begin n++; @(negedge clk); end
  endtask

  task automatic highRun(output int n);
    n = 0;
    while (gateOut && n < 20000) begin n++; @(negedge clk); end
  endtask

  // drop zcdFlag at the j-th low sample, restore it one cycle later
  task automatic zcdAfter(input int j, output int seen);
    seen = 0;
    for (int k = 1; k <= j; k++) begin
      if (gateOut) break;
      seen++;
      if (k == j) zcdFlag = 0;
      @(negedge clk);
    end
    zcdFlag = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int n, n2, w, seen, req, j;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    chkEq("R1 gate low in reset", int'(gateOut), 0);
    rstN = 1;
    lowRun(n);
    chkEq("R1 first restart after reset", n, RST + 1);
    highRun(w);
    chkEq("R2 pulse width 10", w, 10);

    zcdAfter(INH + 5, seen);
    chkEq("R4 zcd start off width", seen, INH + 5);
    chkEq("R4 gate rose on zcd", int'(gateOut), 1);
    highRun(w);
    chkEq("R2 width after zcd", w, 10);

    zcdAfter(INH, seen);
    chkEq("R4 boundary off width INH", seen, INH);
    chkEq("R4 boundary gate rose", int'(gateOut), 1);
    highRun(w);

    zcdAfter(5, seen);
    chkEq("R5 early zcd ignored", int'(gateOut), 0);
    zcdAfter(INH + 3 - 5, seen);
    chkEq("R5 later zcd accepted", int'(gateOut), 1);
    highRun(w);

    zcdAfter(INH - 1, seen);
    chkEq("R5 zcd at INH-1 ignored", int'(gateOut), 0);
    lowRun(n);
    chkEq("R6 restart off width", n + INH - 1, RST);
    highRun(w);

    onReq = 16'hFFFF;
    zcdAfter(INH, seen); highRun(w);
    chkEq("R3 cap at max request", w, MAXON);
    onReq = 16'(MAXON + 1);
    zcdAfter(INH, seen); highRun(w);
    chkEq("R3 cap at MAXON+1", w, MAXON);
    onReq = 16'(MAXON);
    zcdAfter(INH, seen); highRun(w);
    chkEq("R2 request equal MAXON", w, MAXON);
    onReq = 16'd1;
    zcdAfter(INH, seen); highRun(w);
    chkEq("R2 request of one", w, 1);

    onReq = 16'd100;
    ocpFlag = 1;
    zcdAfter(INH, seen); highRun(w);
    chkEq("R7 held trip width", w, BLANK + 1);
    ocpFlag = 1;
    zcdAfter(INH, seen);
    repeat (BLANK) @(negedge clk);
    chkEq("R8 gate high after blanking", int'(gateOut), 1);
    ocpFlag = 0;
    highRun(w);
    chkEq("R8 trip inside blanking ignored", w + BLANK, 100);

    for (int it = 0; it < 16; it++) begin
      req = 1 + int'($urandom % 400);
      j = INH + int'($urandom % 60);
      onReq = 16'(req);
      zcdAfter(j, seen);
      chkEq("R4 random off width", seen, j);
      highRun(w);
      chkEq("R2 random on width", w, expOn(req));
    end

    onReq = 16'd0;
    n = 0;
    while (n < RST + 10 && !gateOut) begin n++; @(negedge clk); end
    chkEq("R9 no pulse for zero request", int'(gateOut), 0);
    onReq = 16'd7;
    lowRun(n2);
    chkEq("R9 zero request restarts interval", n + n2, 2 * RST);
    highRun(w);
    chkEq("R9 next pulse width", w, 7);

    onReq = 16'd200;
    zcdAfter(INH, seen);
    repeat (19) @(negedge clk);
    enable = 0;
    @(negedge clk);
    chkEq("R10 gate drops after enable low", int'(gateOut), 0);
    zcdFlag = 0; @(negedge clk); zcdFlag = 1;
    repeat (INH + 20) @(negedge clk);
    chkEq("R10 no start while disabled", int'(gateOut), 0);
    enable = 1;
    @(negedge clk);
    lowRun(n);
    chkEq("R10 restart counted afresh", n, RST);
    highRun(w);
    chkEq("R10 pulse after re-enable", w, 200);

    onReq = 16'd250;
    zcdAfter(INH, seen);
    disFlag = 1;
    repeat (DIS - 1) @(negedge clk);
    disFlag = 0;
    highRun(w);
    chkEq("R12 short shutdown ignored", w + DIS - 1, 250);

    zcdAfter(INH, seen);
    disFlag = 1;
    highRun(w);
    chkEq("R11 shutdown cut pulse", w, DIS + 1);
    zcdAfter(INH + 10, seen);
    chkEq("R11 zcd ignored while stopped", int'(gateOut), 0);
    disFlag = 0;
    lowRun(n);
    chkEq("R12 resume after shutdown", n, RST + 2);
    highRun(w);
    chkEq("R12 pulse after resume", w, 250);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule